// File: doc/BRIEF.md
# External Parallel Memory Bus Controller

This block runs single-byte read and write cycles to an external memory over pins that the rest of the chip otherwise uses as general-purpose ports. A CPU-side request supplies a direction, an address and, for writes, a data byte. The address comes from one of two places: a 16-bit immediate operand, or a register pair used as a pointer. The controller then drives a 16-bit address bus, an 8-bit bidirectional data bus, and two active-low strobes, one for read and one for write. When the access ends it returns the read byte together with a one-cycle completion pulse.

The block is clocked at twice the system clock rate, so each tick is half a system-clock period. One external access lasts one machine cycle, which is two system clocks or four ticks. This lets every strobe edge land on a register boundary. In the first tick the address is placed on the bus; the read strobe falls in the second tick and the write strobe in the third. The fourth tick is recovery, and the completion pulse is raised during it. Whenever no access is running, every bus pin shows the value held in the port registers for that pin. The port mode and drive logic, wait states and bursts are handled elsewhere.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, and after it until the first request, done_o is 0, rdata_o is 0 and every bus pin shows its port register value.
- R2: With no access running, bus_addr_o equals port_addr_i, bus_data_o equals port_data_i, bus_data_oe_o equals port_data_oe_i, bus_rd_n_o equals port_rd_n_i and bus_wr_n_o equals port_wr_n_i, all in the same cycle the port values change.
- R3: A request accepted at a clock edge starts an access in the cycle that follows. The access lasts exactly four cycles, phases 0 to 3. The address stays constant on bus_addr_o for all four.
- R4: The access address is req_ptr_addr_i when req_use_ptr_i is 1 and req_imm_addr_i when it is 0, sampled at the accepting edge.
- R5: On a write (req_wr_i = 1), bus_data_oe_o is all ones and bus_data_o carries the write byte in all four phases; bus_wr_n_o is 0 only in phase 2 and bus_rd_n_o stays 1.
- R6: On a read (req_wr_i = 0), bus_data_oe_o is all zeros in all four phases; bus_rd_n_o is 0 in phases 1 and 2 and 1 in phases 0 and 3; bus_wr_n_o stays 1.
- R7: A read captures bus_data_i at the clock edge that ends phase 2, where the read strobe rises. rdata_o shows that byte from phase 3 on and holds it until the next read captures. A change on bus_data_i in phase 3 or later has no effect.
- R8: done_o is 1 in phase 3 of every access and 0 in every other cycle.
- R9: A request raised during phases 0 to 2 is ignored. A request raised in phase 3 is accepted, and the next access's phase 0 follows with no idle cycle between.
- R10: A write access leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_use_ptr_i | input | 1 | 1 = pointer address, 0 = immediate address |
| req_imm_addr_i | input | 16 | Immediate operand address |
| req_ptr_addr_i | input | 16 | Register-pair pointer address |
| req_wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Last byte read |
| done_o | output | 1 | One-cycle completion pulse |
| port_addr_i | input | 16 | Port register values for the address pins |
| port_data_i | input | 8 | Port register values for the data pins |
| port_data_oe_i | input | 8 | Port direction for the data pins (1 = drive) |
| port_rd_n_i | input | 1 | Port register value for the read strobe pin |
| port_wr_n_i | input | 1 | Port register value for the write strobe pin |
| bus_addr_o | output | 16 | Address pins |
| bus_data_o | output | 8 | Data pins, driven value |
| bus_data_oe_o | output | 8 | Data pins, per-bit drive enable |
| bus_data_i | input | 8 | Data pins, sensed value |
| bus_rd_n_o | output | 1 | Read strobe pin, active low |
| bus_wr_n_o | output | 1 | Write strobe pin, active low |

## Verification
Two things can happen in the same cycle: one access completes with its done pulse in phase 3, and the next request is accepted. The bench raises a new request exactly in the done cycle of a read. It then expects phase 0 of the new access in the very next cycle, carrying the new address and direction, with done low. It also checks that the first read's byte stayed in rdata_o. A request raised during phase 1 is checked the other way: the address on the pins must not change, and the bus must return to the port values after four cycles.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int unsigned PHASES = 4;
    localparam int unsigned PH_W   = $clog2(PHASES);

    typedef enum logic [PH_W-1:0] {
        PH_ADDR   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_STROBE = 2'd2,
        PH_TAIL   = 2'd3
    } phase_t;

endpackage

// File: rtl/xbus_addr_sel.sv
module xbus_addr_sel #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              use_ptr_i,
    input  logic [ADDR_W-1:0] imm_addr_i,
    input  logic [ADDR_W-1:0] ptr_addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        addr_o = use_ptr_i ? ptr_addr_i : imm_addr_i;
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              active_o,
    output phase_t            phase_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              drive_o,
    output logic              rd_lo_o,
    output logic              wr_lo_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic              active;
        logic              wr;
        phase_t            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rd_lo;
        logic              wr_lo;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start;

    always_comb begin
        seq_d = seq_q;
        start = req_i && (!seq_q.active || seq_q.phase == PH_TAIL);

        if (seq_q.active) begin
            // rising edge of the read strobe: sample the pins
            if (seq_q.phase == PH_STROBE && !seq_q.wr) begin
                seq_d.rdata = bus_data_i;
            end
            if (seq_q.phase == PH_TAIL) begin
                seq_d.active = 1'b0;
            end else begin
                seq_d.phase = phase_t'(seq_q.phase + 1'b1);
            end
        end

        if (start) begin
            seq_d.active = 1'b1;
            seq_d.phase  = PH_ADDR;
            seq_d.wr     = req_wr_i;
            seq_d.addr   = req_addr_i;
            seq_d.wdata  = req_wdata_i;
        end

        seq_d.done  = seq_d.active && (seq_d.phase == PH_TAIL);
        seq_d.rd_lo = seq_d.active && !seq_d.wr &&
                      (seq_d.phase == PH_LEAD || seq_d.phase == PH_STROBE);
        seq_d.wr_lo = seq_d.active && seq_d.wr && (seq_d.phase == PH_STROBE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active_o = seq_q.active;
    assign phase_o  = seq_q.phase;
    assign addr_o   = seq_q.addr;
    assign wdata_o  = seq_q.wdata;
    assign drive_o  = seq_q.wr;
    assign rd_lo_o  = seq_q.rd_lo;
    assign wr_lo_o  = seq_q.wr_lo;
    assign done_o   = seq_q.done;
    assign rdata_o  = seq_q.rdata;

endmodule

// File: rtl/xbus_pin_mux.sv
module xbus_pin_mux #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              active_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    input  logic              acc_drive_i,
    input  logic              acc_rd_lo_i,
    input  logic              acc_wr_lo_i,
    input  logic [ADDR_W-1:0] port_addr_i,
    input  logic [DATA_W-1:0] port_data_i,
    input  logic [DATA_W-1:0] port_data_oe_i,
    input  logic              port_rd_n_i,
    input  logic              port_wr_n_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic [DATA_W-1:0] bus_data_oe_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o
);

    for (genvar a = 0; a < ADDR_W; a++) begin : g_addr_pin
        assign bus_addr_o[a] = active_i ? acc_addr_i[a] : port_addr_i[a];
    end

    for (genvar d = 0; d < DATA_W; d++) begin : g_data_pin
        assign bus_data_o[d]    = active_i ? acc_wdata_i[d] : port_data_i[d];
        assign bus_data_oe_o[d] = active_i ? acc_drive_i    : port_data_oe_i[d];
    end

    assign bus_rd_n_o = active_i ? !acc_rd_lo_i : port_rd_n_i;
    assign bus_wr_n_o = active_i ? !acc_wr_lo_i : port_wr_n_i;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic              req_use_ptr_i,
    input  logic [ADDR_W-1:0] req_imm_addr_i,
    input  logic [ADDR_W-1:0] req_ptr_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    input  logic [ADDR_W-1:0] port_addr_i,
    input  logic [DATA_W-1:0] port_data_i,
    input  logic [DATA_W-1:0] port_data_oe_i,
    input  logic              port_rd_n_i,
    input  logic              port_wr_n_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic [DATA_W-1:0] bus_data_oe_o,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o
);

    logic [ADDR_W-1:0] sel_addr;
    logic              active_q;
    phase_t            phase_q;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic              acc_drive;
    logic              acc_rd_lo;
    logic              acc_wr_lo;

    xbus_addr_sel #(.ADDR_W(ADDR_W)) u_addr_sel (
        .use_ptr_i  (req_use_ptr_i),
        .imm_addr_i (req_imm_addr_i),
        .ptr_addr_i (req_ptr_addr_i),
        .addr_o     (sel_addr)
    );

    xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_wr_i    (req_wr_i),
        .req_addr_i  (sel_addr),
        .req_wdata_i (req_wdata_i),
        .bus_data_i  (bus_data_i),
        .active_o    (active_q),
        .phase_o     (phase_q),
        .addr_o      (acc_addr),
        .wdata_o     (acc_wdata),
        .drive_o     (acc_drive),
        .rd_lo_o     (acc_rd_lo),
        .wr_lo_o     (acc_wr_lo),
        .done_o      (done_o),
        .rdata_o     (rdata_o)
    );

    xbus_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pin_mux (
        .active_i       (active_q),
        .acc_addr_i     (acc_addr),
        .acc_wdata_i    (acc_wdata),
        .acc_drive_i    (acc_drive),
        .acc_rd_lo_i    (acc_rd_lo),
        .acc_wr_lo_i    (acc_wr_lo),
        .port_addr_i    (port_addr_i),
        .port_data_i    (port_data_i),
        .port_data_oe_i (port_data_oe_i),
        .port_rd_n_i    (port_rd_n_i),
        .port_wr_n_i    (port_wr_n_i),
        .bus_addr_o     (bus_addr_o),
        .bus_data_o     (bus_data_o),
        .bus_data_oe_o  (bus_data_oe_o),
        .bus_rd_n_o     (bus_rd_n_o),
        .bus_wr_n_o     (bus_wr_n_o)
    );

endmodule

// File: rtl/xbus_ctrl_checker.sv
module xbus_ctrl_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              active,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_rd_n_o,
    input logic              bus_wr_n_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rdata_o
);

    a_r8_done_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (active && phase == 2'd3));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase != 2'd0) |-> $stable(bus_addr_o));

    a_r3_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase != 2'd3) |=> (active && phase == $past(phase) + 2'd1));

    a_r6_rd_window: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bus_rd_n_o) |-> (phase == 2'd1 || phase == 2'd2));

    a_r5_wr_window: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bus_wr_n_o) |-> (phase == 2'd2 && bus_rd_n_o));

    a_r7_rdata_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o != $past(rdata_o)) |-> done_o);

endmodule

bind xbus_ctrl xbus_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active_q),
    .phase      (phase_q),
    .bus_addr_o (bus_addr_o),
    .bus_rd_n_o (bus_rd_n_o),
    .bus_wr_n_o (bus_wr_n_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i, req_wr_i, req_use_ptr_i;
    logic [15:0] req_imm_addr_i, req_ptr_addr_i;
    logic [7:0]  req_wdata_i;
    logic [7:0]  rdata_o;
    logic        done_o;
    logic [15:0] port_addr_i;
    logic [7:0]  port_data_i, port_data_oe_i;
    logic        port_rd_n_i, port_wr_n_i;
    logic [15:0] bus_addr_o;
    logic [7:0]  bus_data_o, bus_data_oe_o, bus_data_i;
    logic        bus_rd_n_o, bus_wr_n_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_rd;

    always #4 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (.*);

    // {wr, use_ptr, imm addr, ptr addr, write byte, external byte}
    localparam int NV = 6;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h1234, 16'hBEEF, 8'h00, 8'h5A},
        {1'b1, 1'b0, 16'hFFFF, 16'h0001, 8'hA7, 8'h11},
        {1'b0, 1'b1, 16'h0000, 16'hC0DE, 8'h00, 8'hE3},
        {1'b1, 1'b1, 16'h4321, 16'h0000, 8'h3C, 8'h99},
        {1'b0, 1'b1, 16'h7777, 16'h8001, 8'hFF, 8'h00},
        {1'b1, 1'b0, 16'h00FF, 16'hFFFF, 8'h01, 8'hFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " addr"}, 32'(bus_addr_o), 32'(port_addr_i));
        chk({tag, " data"}, 32'(bus_data_o), 32'(port_data_i));
        chk({tag, " oe"},   32'(bus_data_oe_o), 32'(port_data_oe_i));
        chk({tag, " rd_n"}, 32'(bus_rd_n_o), 32'(port_rd_n_i));
        chk({tag, " wr_n"}, 32'(bus_wr_n_o), 32'(port_wr_n_i));
        chk({tag, " done"}, 32'(done_o), 32'd0);
    endtask

    task automatic chk_phase(input int p, input logic wr, input logic [15:0] a,
                             input logic [7:0] wd);
        chk("R3/R4 address", 32'(bus_addr_o), 32'(a));
        chk("R5/R6 data drive", 32'(bus_data_oe_o), wr ? 32'hFF : 32'h0);
        if (wr) chk("R5 write byte", 32'(bus_data_o), 32'(wd));
        chk("R6 read strobe", 32'(bus_rd_n_o), 32'(!(!wr && (p == 1 || p == 2))));
        chk("R5 write strobe", 32'(bus_wr_n_o), 32'(!(wr && p == 2)));
        chk("R8 done", 32'(done_o), 32'(p == 3));
    endtask

    // starts at a falling edge while idle; ends at the falling edge of phase 3
    task automatic run_access(input logic wr, input logic up, input logic [15:0] imm,
                              input logic [15:0] ptr, input logic [7:0] wd,
                              input logic [7:0] ext);
        logic [15:0] a;
        a = up ? ptr : imm;
        req_i = 1'b1; req_wr_i = wr; req_use_ptr_i = up;
        req_imm_addr_i = imm; req_ptr_addr_i = ptr; req_wdata_i = wd;
        bus_data_i = ext;
        @(posedge clk); @(negedge clk);
        req_i = 1'b0;
        for (int p = 0; p < 4; p++) begin
            chk_phase(p, wr, a, wd);
            if (p == 3) begin
                if (!wr) exp_rd = ext;
                chk(wr ? "R10 rdata after write" : "R7 rdata captured",
                    32'(rdata_o), 32'(exp_rd));
                bus_data_i = ~ext;   // late change must be ignored (R7)
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_i = 1'b0; req_wr_i = 1'b0; req_use_ptr_i = 1'b0;
        req_imm_addr_i = '0; req_ptr_addr_i = '0; req_wdata_i = '0;
        port_addr_i = 16'hA5C3; port_data_i = 8'h3C; port_data_oe_i = 8'h0F;
        port_rd_n_i = 1'b1; port_wr_n_i = 1'b0; bus_data_i = 8'h00;
        exp_rd = 8'h00;

        // R1: reset state, a request during reset is not taken
        repeat (2) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        chk_idle("R1 in reset");
        chk("R1 rdata", 32'(rdata_o), 32'd0);
        req_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");

        // R2: idle pins follow new port values at once
        port_addr_i = 16'h5A3C; port_data_i = 8'hC3; port_data_oe_i = 8'hF0;
        port_rd_n_i = 1'b0; port_wr_n_i = 1'b1;
        #1 chk_idle("R2 idle follow");

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_access(VEC[i][49], VEC[i][48], VEC[i][47:32], VEC[i][31:16],
                       VEC[i][15:8], VEC[i][7:0]);
            @(negedge clk);
            chk_idle("R2 back to port");
            chk("R7 rdata hold", 32'(rdata_o), 32'(exp_rd));
            @(negedge clk);
        end

        // R9: request during phase 1 is ignored
        req_i = 1'b1; req_wr_i = 1'b0; req_use_ptr_i = 1'b0;
        req_imm_addr_i = 16'h2468; bus_data_i = 8'h6D;
        @(posedge clk); @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);                       // phase 1
        req_i = 1'b1; req_wr_i = 1'b1; req_imm_addr_i = 16'h9999;
        @(negedge clk);                       // phase 2
        req_i = 1'b0;
        chk("R9 ignored req addr", 32'(bus_addr_o), 32'h2468);
        chk("R9 ignored req dir", 32'(bus_data_oe_o), 32'h0);
        @(negedge clk);                       // phase 3
        exp_rd = 8'h6D;
        chk("R9 first done", 32'(done_o), 32'd1);
        @(negedge clk);
        chk_idle("R9 idle after ignored req");
        chk("R7 rdata R9 case", 32'(rdata_o), 32'h6D);

        // R9: back-to-back, new request in the done cycle
        run_access(1'b0, 1'b1, 16'h0000, 16'h1357, 8'h00, 8'hB2);
        req_i = 1'b1; req_wr_i = 1'b1; req_use_ptr_i = 1'b0;
        req_imm_addr_i = 16'hFACE; req_wdata_i = 8'h4E;
        @(posedge clk); @(negedge clk);
        req_i = 1'b0;
        chk("R9 back-to-back addr", 32'(bus_addr_o), 32'hFACE);
        chk("R9 back-to-back drive", 32'(bus_data_oe_o), 32'hFF);
        chk("R9 back-to-back done low", 32'(done_o), 32'd0);
        chk("R9 first read kept", 32'(rdata_o), 32'hB2);
        repeat (3) @(negedge clk);
        chk("R8 second done", 32'(done_o), 32'd1);
        chk("R10 rdata after write", 32'(rdata_o), 32'hB2);
        @(negedge clk);
        chk_idle("R2 final idle");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule